// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Recency Replacement

This block caches virtual-to-physical page translations in a small, fully associative array. The number of entries is a parameter. Each entry holds a page-aligned virtual tag, a physical base, its own log2 page size, and four attribute bits: global, writable, user and uncacheable. A requester presents one operation per cycle: a lookup, an insert, a full flush, a flush that keeps global entries, or a single-page demap.

A lookup compares the address against every valid entry at once. Only the address bits above each entry's page size take part in the compare. On a hit, the block builds the physical address. It also applies the paging permission rules: user privilege, write protection, and a store-check probe. It then returns a registered hit, miss or fault result one cycle later. A miss is only flagged. Whoever walks the page tables brings the translation back through the insert operation.

Replacement fills a free entry first. When no entry is free, it evicts the entry whose recency stamp is smallest. Stamps come from a running counter and are refreshed on insert. A lookup refreshes the stamp only when the caller asks for it.

Top module: `assoc_xlat_buf`

## Requirements
- R1: Only a lookup (op code 0) produces a response, with rspValid high for exactly the cycle after the request edge. In that cycle exactly one of rspHit and rspMiss is high. Other op codes leave rspValid low, and reset clears rspValid.
- R2: An entry of page size 2^k matches when address bits k and above equal its tag. The translated address is the entry base ORed with address bits below k.
- R3: An insert (op code 1) whose address already hits a valid entry allocates nothing, and the existing mapping stays in place.
- R4: An insert that misses fills the lowest-index free entry. When every entry is valid, it replaces the entry with the smallest recency stamp, with ties going to the lowest index. The new entry gets a fresh stamp, and its tag is the address with bits below its page size cleared.
- R5: A lookup hit refreshes the entry's stamp only when reqTouch is high. A lookup with reqTouch low leaves the replacement order unchanged.
- R6: A full flush (op code 2) invalidates every entry.
- R7: A local flush (op code 3) invalidates only entries whose global bit is 0.
- R8: A demap (op code 4) invalidates the entry that the address hits, if there is one. A demap that misses changes nothing.
- R9: An access is in user mode when reqPriv equals 3 and reqForceSup is 0. A user-mode hit on an entry with its user bit clear faults with rspFaultWrite low.
- R10: A write is bad when the entry is not writable and the access is user mode or wpEnable is 1. A write access that is bad faults with rspFaultWrite high.
- R11: A read with reqStoreProbe high that would be a bad write faults with rspFaultWrite high, unless the user-mode check already faulted it as a read.
- R12: rspNoCache is high only on a fault-free hit of an uncacheable entry. On a miss or a fault, rspPaddr and rspNoCache are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request strobe |
| reqOp | input | 3 | 0 lookup, 1 insert, 2 flush all, 3 flush non-global, 4 demap |
| reqVaddr | input | ADDR_W | Virtual address for the operation |
| reqTouch | input | 1 | Lookup refreshes recency on hit |
| reqWrite | input | 1 | Lookup is a write access |
| reqStoreProbe | input | 1 | Read that checks store permission |
| reqPriv | input | 2 | Current privilege level |
| reqForceSup | input | 1 | Treat access as supervisor |
| wpEnable | input | 1 | Write protection applies to supervisor |
| fillPbase | input | ADDR_W | Physical base for insert |
| fillLogSize | input | LOG_W | log2 page size for insert |
| fillGlobal | input | 1 | Global attribute for insert |
| fillWritable | input | 1 | Writable attribute for insert |
| fillUser | input | 1 | User attribute for insert |
| fillNoCache | input | 1 | Uncacheable attribute for insert |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspMiss | output | 1 | Lookup miss |
| rspFault | output | 1 | Permission fault |
| rspFaultWrite | output | 1 | Fault is tagged as a write |
| rspPaddr | output | ADDR_W | Translated physical address |
| rspNoCache | output | 1 | Translated access is uncacheable |

## Verification
Every lookup result is registered, so it is due one clock edge after the edge that captures the request. The bench drives each request at a falling edge and reads the response at the following falling edge, half a cycle after the result register loads.

Inserts, flushes and demaps update the array at their capture edge. Their effect is therefore judged by a lookup issued in the very next cycle. The replacement order is inferred from which of the earlier pages still hits after a further insert. Every check lookup runs with reqTouch low, so the checks do not change the order they observe.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP      = 3'd0,
    OP_INSERT      = 3'd1,
    OP_FLUSH_ALL   = 3'd2,
    OP_FLUSH_LOCAL = 3'd3,
    OP_DEMAP       = 3'd4
  } xlatOp_e;

  // Strobes from control to datapath, at most one operation per cycle
  typedef struct packed {
    logic lookup;
    logic touch;
    logic insert;
    logic flushAll;
    logic flushLocal;
    logic demap;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                              reqValid,
  input  logic [2:0]                        reqOp,
  input  logic                              reqTouch,
  input  logic                              anyHit,
  input  logic [ENTRIES-1:0]                validVec,
  input  logic [ENTRIES-1:0][SEQ_W-1:0]     stampVec,
  output xlatStrobe_t                       strobe,
  output logic [IDX_W-1:0]                  victimIdx
);
  xlatOp_e op;
  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;

  always_comb begin
    op = xlatOp_e'(reqOp);
    strobe = '0;
    if (reqValid) begin
      case (op)
        OP_LOOKUP: begin
          strobe.lookup = 1'b1;
          strobe.touch  = reqTouch && anyHit;
        end
        OP_INSERT:      strobe.insert     = !anyHit;
        OP_FLUSH_ALL:   strobe.flushAll   = 1'b1;
        OP_FLUSH_LOCAL: strobe.flushLocal = 1'b1;
        OP_DEMAP:       strobe.demap      = anyHit;
        default: ;
      endcase
    end
  end

  // Victim: lowest free slot, else smallest stamp (lowest index on tie)
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !freeFound) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
    oldIdx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (stampVec[i] < stampVec[oldIdx]) oldIdx = IDX_W'(i);
    end
    victimIdx = freeFound ? freeIdx : oldIdx;
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LOG_W  = $clog2(ADDR_W)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xlatStrobe_t                   strobe,
  input  logic [IDX_W-1:0]              victimIdx,
  input  logic [ADDR_W-1:0]             reqVaddr,
  input  logic                          reqWrite,
  input  logic                          reqStoreProbe,
  input  logic [1:0]                    reqPriv,
  input  logic                          reqForceSup,
  input  logic                          wpEnable,
  input  logic [ADDR_W-1:0]             fillPbase,
  input  logic [LOG_W-1:0]              fillLogSize,
  input  logic                          fillGlobal,
  input  logic                          fillWritable,
  input  logic                          fillUser,
  input  logic                          fillNoCache,
  output logic                          anyHit,
  output logic [ENTRIES-1:0]            validVec,
  output logic [ENTRIES-1:0][SEQ_W-1:0] stampVec,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic                          rspMiss,
  output logic                          rspFault,
  output logic                          rspFaultWrite,
  output logic [ADDR_W-1:0]             rspPaddr,
  output logic                          rspNoCache
);
  function automatic logic [ADDR_W-1:0] pageMask(input logic [LOG_W-1:0] lg);
    return ~((ADDR_W'(1) << lg) - ADDR_W'(1));
  endfunction

  logic [ENTRIES-1:0]  validQ, globalQ, writeQ, userQ, ncQ;
  logic [ADDR_W-1:0]   tagQ  [ENTRIES];
  logic [ADDR_W-1:0]   baseQ [ENTRIES];
  logic [LOG_W-1:0]    logQ  [ENTRIES];
  logic [ENTRIES-1:0][SEQ_W-1:0] stampQ;
  logic [SEQ_W-1:0]    seqQ;
  logic [ADDR_W-1:0]   maskVec [ENTRIES];
  logic [ENTRIES-1:0]  hitVec;
  logic [IDX_W-1:0]    hitIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign maskVec[g] = pageMask(logQ[g]);
    assign hitVec[g]  = validQ[g] && (((reqVaddr ^ tagQ[g]) & maskVec[g]) == '0);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyHit   = |hitVec;
  assign validVec = validQ;
  assign stampVec = stampQ;

  // Permission evaluation on the selected entry
  logic userMode, badWrite, userFault, fault, faultWr;
  logic [ADDR_W-1:0] paddr;
  always_comb begin
    userMode  = (reqPriv == 2'd3) && !reqForceSup;
    badWrite  = !writeQ[hitIdx] && (userMode || wpEnable);
    userFault = userMode && !userQ[hitIdx];
    fault     = anyHit && (userFault || (reqWrite && badWrite) || (reqStoreProbe && badWrite));
    faultWr   = fault && (reqWrite || (!userFault && reqStoreProbe && badWrite));
    paddr     = baseQ[hitIdx] | (reqVaddr & ~maskVec[hitIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      globalQ <= '0;
      writeQ  <= '0;
      userQ   <= '0;
      ncQ     <= '0;
      stampQ  <= '0;
      seqQ    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        baseQ[i] <= '0;
        logQ[i]  <= '0;
      end
    end else begin
      if (strobe.insert) begin
        validQ[victimIdx]  <= 1'b1;
        tagQ[victimIdx]    <= reqVaddr & pageMask(fillLogSize);
        baseQ[victimIdx]   <= fillPbase;
        logQ[victimIdx]    <= fillLogSize;
        globalQ[victimIdx] <= fillGlobal;
        writeQ[victimIdx]  <= fillWritable;
        userQ[victimIdx]   <= fillUser;
        ncQ[victimIdx]     <= fillNoCache;
        stampQ[victimIdx]  <= seqQ;
        seqQ               <= seqQ + 1'b1;
      end else if (strobe.touch) begin
        stampQ[hitIdx] <= seqQ;
        seqQ           <= seqQ + 1'b1;
      end else if (strobe.flushAll) begin
        validQ <= '0;
      end else if (strobe.flushLocal) begin
        validQ <= validQ & globalQ;
      end else if (strobe.demap) begin
        validQ[hitIdx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspHit        <= 1'b0;
      rspMiss       <= 1'b0;
      rspFault      <= 1'b0;
      rspFaultWrite <= 1'b0;
      rspPaddr      <= '0;
      rspNoCache    <= 1'b0;
    end else begin
      rspValid      <= strobe.lookup;
      rspHit        <= strobe.lookup && anyHit;
      rspMiss       <= strobe.lookup && !anyHit;
      rspFault      <= strobe.lookup && fault;
      rspFaultWrite <= strobe.lookup && faultWr;
      rspPaddr      <= (strobe.lookup && anyHit && !fault) ? paddr : '0;
      rspNoCache    <= strobe.lookup && anyHit && !fault && ncQ[hitIdx];
    end
  end

  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspHit ^ rspMiss)); // R1
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (!rspFault && rspPaddr == '0 && !rspNoCache)); // R12
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspHit); // R9
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.insert |=> validQ[$past(victimIdx)]); // R4
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validQ == '0)); // R6
  AST_FLUSH_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushLocal |=> ((validQ & ~globalQ) == '0)); // R7
endmodule

// File: rtl/assoc_xlat_buf.sv
module assoc_xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LOG_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqTouch,
  input  logic              reqWrite,
  input  logic              reqStoreProbe,
  input  logic [1:0]        reqPriv,
  input  logic              reqForceSup,
  input  logic              wpEnable,
  input  logic [ADDR_W-1:0] fillPbase,
  input  logic [LOG_W-1:0]  fillLogSize,
  input  logic              fillGlobal,
  input  logic              fillWritable,
  input  logic              fillUser,
  input  logic              fillNoCache,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspFaultWrite,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspNoCache
);
  xlatStrobe_t                   strobe;
  logic [IDX_W-1:0]              victimIdx;
  logic                          anyHit;
  logic [ENTRIES-1:0]            validVec;
  logic [ENTRIES-1:0][SEQ_W-1:0] stampVec;

  xlat_ctrl #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) uCtrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqTouch (reqTouch),
    .anyHit   (anyHit),
    .validVec (validVec),
    .stampVec (stampVec),
    .strobe   (strobe),
    .victimIdx(victimIdx)
  );

  xlat_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) uStore (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .victimIdx    (victimIdx),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .reqStoreProbe(reqStoreProbe),
    .reqPriv      (reqPriv),
    .reqForceSup  (reqForceSup),
    .wpEnable     (wpEnable),
    .fillPbase    (fillPbase),
    .fillLogSize  (fillLogSize),
    .fillGlobal   (fillGlobal),
    .fillWritable (fillWritable),
    .fillUser     (fillUser),
    .fillNoCache  (fillNoCache),
    .anyHit       (anyHit),
    .validVec     (validVec),
    .stampVec     (stampVec),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspMiss      (rspMiss),
    .rspFault     (rspFault),
    .rspFaultWrite(rspFaultWrite),
    .rspPaddr     (rspPaddr),
    .rspNoCache   (rspNoCache)
  );
endmodule

// File: tb/assoc_xlat_buf_test.sv
`timescale 1ns/1ps
module assoc_xlat_buf_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [31:0] reqVaddr = '0;
  logic reqTouch = 1'b0, reqWrite = 1'b0, reqStoreProbe = 1'b0;
  logic [1:0] reqPriv = '0;
  logic reqForceSup = 1'b0, wpEnable = 1'b0;
  logic [31:0] fillPbase = '0;
  logic [4:0] fillLogSize = 5'd12;
  logic fillGlobal = 1'b0, fillWritable = 1'b0, fillUser = 1'b0, fillNoCache = 1'b0;
  logic rspValid, rspHit, rspMiss, rspFault, rspFaultWrite, rspNoCache;
  logic [31:0] rspPaddr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assoc_xlat_buf uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqVaddr(reqVaddr),
    .reqTouch(reqTouch), .reqWrite(reqWrite), .reqStoreProbe(reqStoreProbe),
    .reqPriv(reqPriv), .reqForceSup(reqForceSup), .wpEnable(wpEnable),
    .fillPbase(fillPbase), .fillLogSize(fillLogSize), .fillGlobal(fillGlobal),
    .fillWritable(fillWritable), .fillUser(fillUser), .fillNoCache(fillNoCache),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspFaultWrite(rspFaultWrite), .rspPaddr(rspPaddr), .rspNoCache(rspNoCache)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        probe;
    logic [1:0]  priv;
    logic        fsup;
    logic        wp;
    logic        eHit;
    logic        eFault;
    logic        eFw;
    logic [31:0] ePa;
    logic        eNc;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1abc, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_0abc, 1'b0},
    '{32'h0000_1abc, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_0abc, 1'b0},
    '{32'h0055_4321, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1015_4321, 1'b0},
    '{32'h0055_4321, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0055_4321, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1015_4321, 1'b0},
    '{32'h0055_4321, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0055_4321, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0000_3010, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9000_0010, 1'b1},
    '{32'h0000_3010, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
    '{32'h0000_3010, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9000_0010, 1'b1},
    '{32'h0000_2000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
    '{32'h0000_3010, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9000_0010, 1'b1},
    '{32'h0000_3010, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one op at a falling edge; return at the next falling edge,
  // half a cycle after the response register has loaded.
  task automatic doOp(input logic [2:0] op, input logic [31:0] va);
    @(negedge clk);
    reqOp = op;
    reqVaddr = va;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pb, input logic [4:0] lg,
                      input logic g, input logic w, input logic u, input logic nc);
    fillPbase = pb;
    fillLogSize = lg;
    fillGlobal = g;
    fillWritable = w;
    fillUser = u;
    fillNoCache = nc;
    doOp(3'd1, va);
  endtask

  task automatic plainLookup(input logic [31:0] va);
    reqWrite = 1'b0;
    reqStoreProbe = 1'b0;
    reqPriv = 2'd0;
    reqForceSup = 1'b0;
    wpEnable = 1'b0;
    reqTouch = 1'b0;
    doOp(3'd0, va);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rspValid", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;

    fill(32'h0000_1234, 32'h8000_0000, 5'd12, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R1 no response after insert", {31'b0, rspValid}, 32'd0);
    fill(32'h0040_0000, 32'h1000_0000, 5'd21, 1'b1, 1'b0, 1'b1, 1'b0);
    fill(32'h0000_3000, 32'h9000_0000, 5'd12, 1'b0, 1'b1, 1'b0, 1'b1);

    // Vector table: R2 R9 R10 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      reqWrite = VECS[i].wr;
      reqStoreProbe = VECS[i].probe;
      reqPriv = VECS[i].priv;
      reqForceSup = VECS[i].fsup;
      wpEnable = VECS[i].wp;
      reqTouch = 1'b0;
      doOp(3'd0, VECS[i].va);
      check($sformatf("R1 vector %0d valid", i), {31'b0, rspValid}, 32'd1);
      check($sformatf("R2 vector %0d hit", i), {31'b0, rspHit}, {31'b0, VECS[i].eHit});
      check($sformatf("R9 R10 vector %0d fault", i), {31'b0, rspFault}, {31'b0, VECS[i].eFault});
      check($sformatf("R11 vector %0d faultWrite", i), {31'b0, rspFaultWrite}, {31'b0, VECS[i].eFw});
      check($sformatf("R2 vector %0d paddr", i), rspPaddr, VECS[i].ePa);
      check($sformatf("R12 vector %0d noCache", i), {31'b0, rspNoCache}, {31'b0, VECS[i].eNc});
    end

    // R3: duplicate insert keeps the original mapping
    fill(32'h0000_1000, 32'hA000_0000, 5'd12, 1'b0, 1'b1, 1'b1, 1'b0);
    plainLookup(32'h0000_1004);
    check("R3 duplicate insert keeps base", rspPaddr, 32'h8000_0004);

    // R8: demap of a missing page changes nothing, demap of a hit removes it
    doOp(3'd4, 32'h0000_7000);
    plainLookup(32'h0000_1004);
    check("R8 demap miss leaves entry", {31'b0, rspHit}, 32'd1);
    doOp(3'd4, 32'h0000_3fff);
    plainLookup(32'h0000_3010);
    check("R8 demapped page misses", {31'b0, rspMiss}, 32'd1);
    plainLookup(32'h0000_1004);
    check("R8 other page survives demap", {31'b0, rspHit}, 32'd1);

    // R7: local flush keeps global entry
    doOp(3'd3, 32'h0);
    plainLookup(32'h0000_1004);
    check("R7 non-global flushed", {31'b0, rspMiss}, 32'd1);
    plainLookup(32'h0040_0008);
    check("R7 global kept", rspPaddr, 32'h1000_0008);

    // R6: full flush
    doOp(3'd2, 32'h0);
    plainLookup(32'h0040_0008);
    check("R6 global flushed by full flush", {31'b0, rspMiss}, 32'd1);

    // R4 R5: replacement order
    for (int k = 0; k < 8; k++) begin
      fill(32'h0010_0000 + 32'(k) * 32'h1000, 32'h2000_0000 + 32'(k) * 32'h1000,
           5'd12, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    plainLookup(32'h0010_7000);
    check("R4 eighth entry fits without eviction", {31'b0, rspHit}, 32'd1);
    reqTouch = 1'b1;
    doOp(3'd0, 32'h0010_0000);
    reqTouch = 1'b0;
    doOp(3'd0, 32'h0010_1000);
    fill(32'h0010_8000, 32'h2000_8000, 5'd12, 1'b0, 1'b1, 1'b1, 1'b0);
    plainLookup(32'h0010_1000);
    check("R5 untouched page evicted", {31'b0, rspMiss}, 32'd1);
    plainLookup(32'h0010_0010);
    check("R4 touched page kept", rspPaddr, 32'h2000_0010);
    plainLookup(32'h0010_8020);
    check("R4 new page present", rspPaddr, 32'h2000_8020);
    fill(32'h0010_9000, 32'h2000_9000, 5'd12, 1'b0, 1'b1, 1'b1, 1'b0);
    plainLookup(32'h0010_2000);
    check("R4 next oldest evicted", {31'b0, rspMiss}, 32'd1);
    plainLookup(32'h0010_3000);
    check("R4 younger page kept", {31'b0, rspHit}, 32'd1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule